// File: doc/BRIEF.md
# Snooping Coherent Bus Router

This block joins several cache-facing (upstream) ports to a single memory-facing (downstream) port. A request taken from an upstream port goes downstream tagged with the number of the port that sent it. When the request targets cacheable memory, the bus first sends it as a snoop to every other upstream port. It then collects a one-cycle hit indication from those ports and sets an inhibit flag on the downstream request if any of them reports a hit. Memory uses that flag to stay silent, so that the snooping cache alone supplies the data.

Snoops arriving from downstream go to all upstream ports. Replies travel back by the destination number they carry. Downstream replies go to an upstream port. Snoop replies go either to an upstream port or, when the destination number equals the port count, out on the downstream snoop-reply channel.

Each delivery towards an upstream port, and each snoop reply sent downstream, opens a busy window of `BUSY_CYC` cycles. During that window new upstream requests, downstream replies and downstream snoops are held off. Snoop replies are still taken.

Top module: `snoop_xbar`

## Requirements
- R1: An accepted upstream request appears on the downstream request channel with the same address and with `dn_req_src` equal to the index of the port that sent it.
- R2: A cacheable upstream request is presented for exactly one cycle on `up_snp_valid` to every upstream port except its sender, with the request address and `up_snp_src` equal to the sender index. A non-cacheable request produces no snoop.
- R3: `dn_req_inhibit` is 1 exactly when some snooped port drives its `up_snp_hit` bit high in the cycle the snoop is visible. The hit bit of the sending port is ignored. Non-cacheable requests carry inhibit 0.
- R4: A downstream reply accepted with destination d (d < NUP) drives `up_rsp_valid` to the one-hot value 1<<d, with its data, for one cycle, in the cycle after acceptance.
- R5: An accepted downstream snoop is presented for one cycle to all upstream ports with its address and with `up_snp_src` equal to NUP.
- R6: A snoop reply with destination d < NUP is delivered one-hot on `up_rsp_valid` with its data. A snoop reply with destination NUP is delivered on `dn_srsp_valid`/`dn_srsp_data` instead. In both cases the delivery comes in the cycle after acceptance.
- R7: For `BUSY_CYC` cycles starting with the cycle in which any snoop, upstream reply or downstream snoop reply is presented, `up_req_ready`, `dn_rsp_ready` and `dn_snp_ready` are all 0. `up_srsp_ready` is unaffected by this window.
- R8: Competing upstream requests are granted round-robin: the winner is the first requesting port after the last granted one, in rising index order with wrap-around. Port 0 wins first after reset.
- R9: A downstream snoop is taken before an upstream request. A downstream reply is taken before any snoop reply. Among snoop replies, the lowest port index wins.
- R10: While `dn_req_valid` is high and `dn_req_ready` is low, the downstream request and its fields stay unchanged.
- R11: After reset, `up_snp_valid`, `up_rsp_valid`, `dn_req_valid` and `dn_srsp_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req_valid | input | NUP | Request valid per upstream port |
| up_req_ready | output | NUP | Request accepted per upstream port |
| up_req_addr | input | NUP*AW | Request address, port k in bits k*AW upward |
| up_req_cacheable | input | NUP | Request targets cacheable memory |
| up_snp_valid | output | NUP | Snoop presented to each upstream port |
| up_snp_addr | output | AW | Snoop address |
| up_snp_src | output | ID_W | Snoop originator (NUP means downstream) |
| up_snp_hit | input | NUP | Snooped port will supply the data |
| up_srsp_valid | input | NUP | Snoop reply valid per upstream port |
| up_srsp_ready | output | NUP | Snoop reply accepted |
| up_srsp_dst | input | NUP*ID_W | Snoop reply destination per port |
| up_srsp_data | input | NUP*DW | Snoop reply data per port |
| up_rsp_valid | output | NUP | Reply delivered to each upstream port |
| up_rsp_data | output | DW | Reply data |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_addr | output | AW | Downstream request address |
| dn_req_src | output | ID_W | Index of the sending upstream port |
| dn_req_inhibit | output | 1 | A cache supplies the data; memory must not answer |
| dn_rsp_valid | input | 1 | Downstream reply valid |
| dn_rsp_ready | output | 1 | Downstream reply accepted |
| dn_rsp_dst | input | ID_W | Upstream port that receives the reply |
| dn_rsp_data | input | DW | Downstream reply data |
| dn_snp_valid | input | 1 | Snoop from downstream valid |
| dn_snp_ready | output | 1 | Snoop from downstream accepted |
| dn_snp_addr | input | AW | Snoop address from downstream |
| dn_srsp_valid | output | 1 | Snoop reply delivered downstream |
| dn_srsp_data | output | DW | Snoop reply data delivered downstream |

## Verification
The assertions assume the following about the block's inputs:
- downstream replies always name an upstream port below NUP;
- the snoop-hit bits are meaningful only in the single cycle a snoop is visible;
- no upstream port expects back-pressure on snoops or replies.

The stimulus keeps to these rules. It draws reply destinations only from the legal range, and drives hit bits only in the snoop cycle before clearing them. It waits out the busy window between random operations so that each expected value follows from one transaction. Directed sequences then overlap operations on purpose to cover the priority order and the busy window.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SNOOP = 2'd1,
    ST_ISSUE = 2'd2
  } req_st_e;
endpackage

// File: rtl/sxb_rr_arb.sv
module sxb_rr_arb #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;
  int idx;

  // search downward so the nearest port after last_q is the final overwrite
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    idx     = 0;
    for (int k = N; k >= 1; k--) begin
      idx = (int'(last_q) + k) % N;
      if (req[idx]) begin
        gnt      = '0;
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      last_q <= IW'(N - 1);
    else if (adv) last_q <= gnt_idx;
  end
endmodule

// File: rtl/sxb_busy_timer.sv
module sxb_busy_timer #(
  parameter int CYC = 2,
  localparam int CW = $clog2(CYC + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= CW'(CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/sxb_rsp_route.sv
module sxb_rsp_route #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int IW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic            dn_rsp_valid,
  input  logic [IW-1:0]   dn_rsp_dst,
  input  logic [DW-1:0]   dn_rsp_data,
  input  logic [N-1:0]    srsp_valid,
  input  logic [N*IW-1:0] srsp_dst,
  input  logic [N*DW-1:0] srsp_data,
  output logic            dn_rsp_ready,
  output logic [N-1:0]    srsp_ready,
  output logic [N-1:0]    up_rsp_valid,
  output logic [DW-1:0]   up_rsp_data,
  output logic            dn_srsp_valid,
  output logic [DW-1:0]   dn_srsp_data,
  output logic            sent
);
  logic          take_dn, take_s, any_s;
  int            sel;
  logic [IW-1:0] dst;
  logic [DW-1:0] data;

  always_comb begin
    any_s = 1'b0;
    sel   = 0;
    for (int k = N - 1; k >= 0; k--) begin
      if (srsp_valid[k]) begin
        any_s = 1'b1;
        sel   = k;
      end
    end
    dn_rsp_ready = !busy;
    take_dn      = dn_rsp_valid && !busy;
    take_s       = any_s && !take_dn;
    srsp_ready   = '0;
    if (take_s) srsp_ready[sel] = 1'b1;
    dst  = take_dn ? dn_rsp_dst  : srsp_dst[sel*IW +: IW];
    data = take_dn ? dn_rsp_data : srsp_data[sel*DW +: DW];
    sent = take_dn || take_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_rsp_valid  <= '0;
      dn_srsp_valid <= 1'b0;
      up_rsp_data   <= '0;
      dn_srsp_data  <= '0;
    end else begin
      up_rsp_valid  <= '0;
      dn_srsp_valid <= 1'b0;
      if (take_s && dst == IW'(N)) begin
        dn_srsp_valid <= 1'b1;
        dn_srsp_data  <= data;
      end else if (sent) begin
        for (int k = 0; k < N; k++) up_rsp_valid[k] <= (dst == IW'(k));
        up_rsp_data <= data;
      end
    end
  end
endmodule

// File: rtl/snoop_xbar.sv
module snoop_xbar
  import sxb_pkg::*;
#(
  parameter int NUP      = 3,
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int BUSY_CYC = 2,
  localparam int ID_W    = $clog2(NUP + 1),
  localparam int GW      = (NUP > 1) ? $clog2(NUP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUP-1:0]    up_req_valid,
  output logic [NUP-1:0]    up_req_ready,
  input  logic [NUP*AW-1:0] up_req_addr,
  input  logic [NUP-1:0]    up_req_cacheable,
  output logic [NUP-1:0]    up_snp_valid,
  output logic [AW-1:0]     up_snp_addr,
  output logic [ID_W-1:0]   up_snp_src,
  input  logic [NUP-1:0]    up_snp_hit,
  input  logic [NUP-1:0]    up_srsp_valid,
  output logic [NUP-1:0]    up_srsp_ready,
  input  logic [NUP*ID_W-1:0] up_srsp_dst,
  input  logic [NUP*DW-1:0] up_srsp_data,
  output logic [NUP-1:0]    up_rsp_valid,
  output logic [DW-1:0]     up_rsp_data,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [AW-1:0]     dn_req_addr,
  output logic [ID_W-1:0]   dn_req_src,
  output logic              dn_req_inhibit,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [ID_W-1:0]   dn_rsp_dst,
  input  logic [DW-1:0]     dn_rsp_data,
  input  logic              dn_snp_valid,
  output logic              dn_snp_ready,
  input  logic [AW-1:0]     dn_snp_addr,
  output logic              dn_srsp_valid,
  output logic [DW-1:0]     dn_srsp_data
);
  req_st_e        state_q;
  logic           busy, rsp_sent, snp_fire;
  logic           req_ok, acc, snp_take, sel_cache;
  logic [NUP-1:0] gnt;
  logic [GW-1:0]  gnt_idx;
  logic [AW-1:0]  sel_addr;

  sxb_rr_arb #(.N(NUP)) arb_i (
    .clk(clk), .rst(rst), .req(up_req_valid), .adv(acc),
    .gnt(gnt), .gnt_idx(gnt_idx)
  );

  sxb_busy_timer #(.CYC(BUSY_CYC)) busy_i (
    .clk(clk), .rst(rst), .start(snp_fire || rsp_sent), .busy(busy)
  );

  sxb_rsp_route #(.N(NUP), .DW(DW), .IW(ID_W)) rsp_i (
    .clk(clk), .rst(rst), .busy(busy),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_dst(dn_rsp_dst), .dn_rsp_data(dn_rsp_data),
    .srsp_valid(up_srsp_valid), .srsp_dst(up_srsp_dst), .srsp_data(up_srsp_data),
    .dn_rsp_ready(dn_rsp_ready), .srsp_ready(up_srsp_ready),
    .up_rsp_valid(up_rsp_valid), .up_rsp_data(up_rsp_data),
    .dn_srsp_valid(dn_srsp_valid), .dn_srsp_data(dn_srsp_data),
    .sent(rsp_sent)
  );

  always_comb begin
    snp_take     = (state_q == ST_IDLE) && !busy && dn_snp_valid;
    dn_snp_ready = (state_q == ST_IDLE) && !busy;
    req_ok       = (state_q == ST_IDLE) && !busy && !dn_snp_valid;
    up_req_ready = req_ok ? gnt : '0;
    acc          = req_ok && (up_req_valid != '0);
    sel_addr     = up_req_addr[gnt_idx*AW +: AW];
    sel_cache    = up_req_cacheable[gnt_idx];
    snp_fire     = snp_take || (acc && sel_cache);
    dn_req_valid = (state_q == ST_ISSUE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      up_snp_valid   <= '0;
      up_snp_addr    <= '0;
      up_snp_src     <= '0;
      dn_req_addr    <= '0;
      dn_req_src     <= '0;
      dn_req_inhibit <= 1'b0;
    end else begin
      up_snp_valid <= '0;
      case (state_q)
        ST_IDLE: begin
          if (snp_take) begin
            up_snp_valid <= '1;
            up_snp_addr  <= dn_snp_addr;
            up_snp_src   <= ID_W'(NUP);
          end else if (acc) begin
            dn_req_addr    <= sel_addr;
            dn_req_src     <= ID_W'(gnt_idx);
            dn_req_inhibit <= 1'b0;
            if (sel_cache) begin
              up_snp_valid <= ~gnt;
              up_snp_addr  <= sel_addr;
              up_snp_src   <= ID_W'(gnt_idx);
              state_q      <= ST_SNOOP;
            end else begin
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_SNOOP: begin
          dn_req_inhibit <= |(up_snp_hit & up_snp_valid);
          state_q        <= ST_ISSUE;
        end
        ST_ISSUE: if (dn_req_ready) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_xbar_chk.sv
module snoop_xbar_chk #(
  parameter int NUP      = 3,
  parameter int AW       = 16,
  parameter int BUSY_CYC = 2,
  parameter int ID_W     = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic [NUP-1:0]  up_req_ready,
  input logic [NUP-1:0]  up_snp_valid,
  input logic [ID_W-1:0] up_snp_src,
  input logic [NUP-1:0]  up_rsp_valid,
  input logic            dn_srsp_valid,
  input logic            dn_req_valid,
  input logic            dn_req_ready,
  input logic [AW-1:0]   dn_req_addr,
  input logic [ID_W-1:0] dn_req_src,
  input logic            dn_req_inhibit,
  input logic            dn_rsp_ready,
  input logic            dn_snp_ready
);
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy |-> (up_req_ready == '0 && !dn_rsp_ready && !dn_snp_ready));

  a_r7_busy_after_delivery: assert property (@(posedge clk) disable iff (rst)
    ((up_rsp_valid != '0) || dn_srsp_valid || (up_snp_valid != '0)) |-> (BUSY_CYC == 0 || busy));

  a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(up_req_ready));

  a_r2_no_self_snoop: assert property (@(posedge clk) disable iff (rst)
    ((up_snp_valid != '0) && up_snp_src != ID_W'(NUP)) |-> (((up_snp_valid >> up_snp_src) & 1) == 0));

  a_r5_dn_snoop_all: assert property (@(posedge clk) disable iff (rst)
    ((up_snp_valid != '0) && up_snp_src == ID_W'(NUP)) |-> (&up_snp_valid));

  a_r6_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dn_srsp_valid, up_rsp_valid}));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && !dn_req_ready) |=>
      (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_src) && $stable(dn_req_inhibit)));
endmodule

bind snoop_xbar snoop_xbar_chk #(.NUP(NUP), .AW(AW), .BUSY_CYC(BUSY_CYC), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst(rst), .busy(busy),
  .up_req_ready(up_req_ready), .up_snp_valid(up_snp_valid), .up_snp_src(up_snp_src),
  .up_rsp_valid(up_rsp_valid), .dn_srsp_valid(dn_srsp_valid),
  .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_addr(dn_req_addr),
  .dn_req_src(dn_req_src), .dn_req_inhibit(dn_req_inhibit),
  .dn_rsp_ready(dn_rsp_ready), .dn_snp_ready(dn_snp_ready)
);

// File: tb/snoop_xbar_tb_top.sv
module snoop_xbar_tb_top;
  localparam int NUP = 3;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BUSY = 2;
  localparam int IDW = $clog2(NUP + 1);
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [NUP-1:0] up_req_valid = '0, up_req_cacheable = '0, up_snp_hit = '0, up_srsp_valid = '0;
  logic [NUP*AW-1:0] up_req_addr = '0;
  logic [NUP*IDW-1:0] up_srsp_dst = '0;
  logic [NUP*DW-1:0] up_srsp_data = '0;
  logic dn_req_ready = 1, dn_rsp_valid = 0, dn_snp_valid = 0;
  logic [IDW-1:0] dn_rsp_dst = '0;
  logic [DW-1:0] dn_rsp_data = '0;
  logic [AW-1:0] dn_snp_addr = '0;
  logic [NUP-1:0] up_req_ready, up_snp_valid, up_srsp_ready, up_rsp_valid;
  logic [AW-1:0] up_snp_addr, dn_req_addr;
  logic [IDW-1:0] up_snp_src, dn_req_src;
  logic [DW-1:0] up_rsp_data, dn_srsp_data;
  logic dn_req_valid, dn_req_inhibit, dn_rsp_ready, dn_snp_ready, dn_srsp_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int last_gnt = NUP - 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_xbar #(.NUP(NUP), .AW(AW), .DW(DW), .BUSY_CYC(BUSY)) dut_i (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int rr_next(input int last, input logic [NUP-1:0] mask);
    for (int k = 1; k <= NUP; k++) if (mask[(last + k) % NUP]) return (last + k) % NUP;
    return -1;
  endfunction

  function automatic logic [NUP-1:0] others(input int p);
    return ~(NUP'(1) << p);
  endfunction

  task automatic quiet();
    repeat (BUSY + 3) @(negedge clk);
  endtask

  task automatic do_req(input int p, input logic [AW-1:0] a, input bit c, input logic [NUP-1:0] hits);
    @(negedge clk);
    up_req_valid[p] = 1; up_req_addr[p*AW +: AW] = a; up_req_cacheable[p] = c;
    #1 chk("R8", "ready single", up_req_ready, NUP'(1) << p);
    last_gnt = p;
    @(negedge clk);
    up_req_valid[p] = 0;
    if (c) begin
      chk("R2", "snoop mask", up_snp_valid, others(p));
      chk("R2", "snoop addr", up_snp_addr, a);
      chk("R2", "snoop src", up_snp_src, p);
      up_snp_hit = hits;
      @(negedge clk);
      up_snp_hit = '0;
      chk("R3", "inhibit", dn_req_inhibit, |(hits & others(p)));
    end else begin
      chk("R2", "no snoop", up_snp_valid, 0);
      chk("R3", "inhibit nc", dn_req_inhibit, 0);
    end
    chk("R1", "dn valid", dn_req_valid, 1);
    chk("R1", "dn addr", dn_req_addr, a);
    chk("R1", "dn src", dn_req_src, p);
    quiet();
  endtask

  task automatic do_dnrsp(input int d, input logic [DW-1:0] v);
    @(negedge clk);
    dn_rsp_valid = 1; dn_rsp_dst = IDW'(d); dn_rsp_data = v;
    #1 chk("R4", "dn rsp ready", dn_rsp_ready, 1);
    @(negedge clk);
    dn_rsp_valid = 0;
    chk("R4", "rsp route", up_rsp_valid, NUP'(1) << d);
    chk("R4", "rsp data", up_rsp_data, v);
    quiet();
  endtask

  task automatic do_srsp(input int p, input int d, input logic [DW-1:0] v);
    @(negedge clk);
    up_srsp_valid[p] = 1; up_srsp_dst[p*IDW +: IDW] = IDW'(d); up_srsp_data[p*DW +: DW] = v;
    #1 chk("R6", "srsp ready", up_srsp_ready, NUP'(1) << p);
    @(negedge clk);
    up_srsp_valid[p] = 0;
    if (d == NUP) begin
      chk("R6", "to dn valid", dn_srsp_valid, 1);
      chk("R6", "to dn data", dn_srsp_data, v);
      chk("R6", "no up", up_rsp_valid, 0);
    end else begin
      chk("R6", "to up", up_rsp_valid, NUP'(1) << d);
      chk("R6", "to up data", up_rsp_data, v);
      chk("R6", "no dn", dn_srsp_valid, 0);
    end
    quiet();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NUP-1:0] clr;
    int got, zeros;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11", "snp", up_snp_valid, 0);
    chk("R11", "rsp", up_rsp_valid, 0);
    chk("R11", "dnreq", dn_req_valid, 0);
    chk("R11", "dnsrsp", dn_srsp_valid, 0);

    // R8 round robin: all ports, then ports 0 and 2
    for (int round = 0; round < 2; round++) begin
      got = 0;
      up_req_valid = (round == 0) ? 3'b111 : 3'b101;
      for (int c = 0; c < 40 && up_req_valid != 0; c++) begin
        #1;
        clr = up_req_ready & up_req_valid;
        if (clr != 0) begin
          chk("R8", "rr order", $clog2(clr), rr_next(last_gnt, up_req_valid));
          last_gnt = $clog2(clr);
          got++;
        end
        @(negedge clk);
        up_req_valid &= ~clr;
      end
      chk("R8", "rr count", got, (round == 0) ? 3 : 2);
      quiet();
    end

    // directed requests
    do_req(1, 16'h1234, 1, 3'b001);
    do_req(1, 16'h2222, 1, 3'b010);
    do_req(0, 16'h0F0F, 0, 3'b111);
    do_req(2, 16'hBEEF, 1, 3'b000);
    do_dnrsp(0, 16'hA5A5);
    do_dnrsp(2, 16'h5A5A);
    do_srsp(0, 2, 16'h1111);
    do_srsp(2, NUP, 16'h7777);

    // R5 + R7: downstream snoop then busy window
    @(negedge clk);
    dn_snp_valid = 1; dn_snp_addr = 16'hC0DE;
    #1 chk("R5", "dn snp ready", dn_snp_ready, 1);
    @(negedge clk);
    dn_snp_valid = 0;
    chk("R5", "all snooped", up_snp_valid, 3'b111);
    chk("R5", "src", up_snp_src, NUP);
    chk("R5", "addr", up_snp_addr, 16'hC0DE);
    dn_rsp_valid = 1; dn_rsp_dst = 1; dn_rsp_data = 16'h4242; up_req_valid[0] = 1;
    zeros = 0;
    for (int c = 0; c < 10; c++) begin
      #1;
      if (dn_rsp_ready) break;
      chk("R7", "req blocked", up_req_ready, 0);
      chk("R7", "snp blocked", dn_snp_ready, 0);
      zeros++;
      @(negedge clk);
    end
    chk("R7", "busy length", zeros, BUSY);
    chk("R9", "rsp wins srsp? req port0 taken", up_req_ready, 3'b001);
    last_gnt = 0;
    @(negedge clk);
    dn_rsp_valid = 0; up_req_valid = 0;
    chk("R4", "after busy route", up_rsp_valid, 3'b010);
    chk("R1", "after busy req", dn_req_valid, 1);
    quiet();

    // R7: snoop replies pass during busy; R9 priorities
    @(negedge clk);
    dn_snp_valid = 1; up_req_valid[1] = 1;
    #1 chk("R9", "snoop over req", up_req_ready, 0);
    chk("R9", "snoop taken", dn_snp_ready, 1);
    @(negedge clk);
    dn_snp_valid = 0; up_req_valid = 0;
    up_srsp_valid[1] = 1; up_srsp_dst[1*IDW +: IDW] = 0; up_srsp_data[1*DW +: DW] = 16'h3333;
    dn_rsp_valid = 1; dn_rsp_dst = 2;
    #1 chk("R7", "srsp while busy", up_srsp_ready, 3'b010);
    chk("R7", "dnrsp while busy", dn_rsp_ready, 0);
    @(negedge clk);
    up_srsp_valid = 0; dn_rsp_valid = 0;
    chk("R6", "busy srsp route", up_rsp_valid, 3'b001);
    quiet();
    @(negedge clk);
    dn_rsp_valid = 1; dn_rsp_dst = 2; up_srsp_valid = 3'b101;
    up_srsp_dst = '0;
    #1 chk("R9", "dn rsp first", dn_rsp_ready, 1);
    chk("R9", "srsp waits", up_srsp_ready, 0);
    @(negedge clk);
    dn_rsp_valid = 0;
    #1 chk("R9", "lowest srsp", up_srsp_ready, 3'b001);
    @(negedge clk);
    up_srsp_valid[0] = 0;
    #1 chk("R9", "next srsp", up_srsp_ready, 3'b100);
    @(negedge clk);
    up_srsp_valid = 0;
    quiet();

    // R10: downstream back-pressure
    dn_req_ready = 0;
    @(negedge clk);
    up_req_valid[2] = 1; up_req_addr[2*AW +: AW] = 16'h9999; up_req_cacheable[2] = 0;
    @(negedge clk);
    up_req_valid = 0;
    last_gnt = 2;
    for (int c = 0; c < 3; c++) begin
      chk("R10", "held valid", dn_req_valid, 1);
      chk("R10", "held addr", dn_req_addr, 16'h9999);
      chk("R10", "held src", dn_req_src, 2);
      @(negedge clk);
    end
    dn_req_ready = 1;
    @(negedge clk);
    chk("R10", "released", dn_req_valid, 0);
    quiet();

    // random mix
    for (int i = 0; i < 40; i++) begin
      int op = $urandom_range(0, 2);
      if (op == 0)
        do_req($urandom_range(0, NUP - 1), AW'($urandom), 1'($urandom), NUP'($urandom));
      else if (op == 1)
        do_dnrsp($urandom_range(0, NUP - 1), DW'($urandom));
      else
        do_srsp($urandom_range(0, NUP - 1), $urandom_range(0, NUP), DW'($urandom));
    end
    finish_run();
  end
endmodule